// File: doc/BRIEF.md
# TLB Range-Invalidate Access Gate

This block decides what happens when software issues the range-based TLB invalidation instruction that covers all address-space identifiers for the EL1&0 regime. Each cycle it may accept one request. A request carries the executing exception level, a flag for which variant was issued (the plain form, or the relaxed form whose completion waits only for accesses that lack the extra-strict attribute), the 64-bit operand, the implemented-feature flags and the relevant hypervisor and monitor control bits.

One cycle after it accepts a request, the block pulses a response valid together with exactly one outcome: undefined instruction, trap to EL2 with a syndrome class, silent no-op, or an invalidation request. For an invalidation request the response also carries the following attributes:
- the target translation regime;
- whether the request is broadcast to the inner-shareable domain;
- whether the current VMID qualifies the request;
- whether accesses with the extra-strict attribute are left out;
- a level hint;
- the operand, unchanged.

The invalidation itself and the register-file read are done elsewhere.

Top module: `tlbi_range_gate`

## Requirements
- R1: The outcome is undefined when the relaxed variant is issued while the extra-strict-attribute feature (`feat_xattr`) is absent. This check is applied first, at every level. The outcome is also undefined at level 0 (`req_el` = 2'd0) for both variants.
- R2: At level 1 (`req_el` = 2'd1), when EL2 is enabled and `ctl_tlb_trap` is 1, the outcome is a trap, and `rsp_class` is 0x18. `rsp_class` is 0 on every response that is not a trap.
- R3: At level 1 with EL2 enabled, a trap with class 0x18 also occurs when all of the following hold: the fine-grained-trap feature is present, EL3 is absent or `ctl_fgt_en` is 1, and `ctl_fgt_inst` is 1. For the relaxed variant this trap further requires the hypervisor-extension feature, and either `ctl_xctl_on` is 0 or `ctl_xctl_fgtx` is 0.
- R4: An invalidation request issued at level 1 is inner-shareable (`rsp_inner` = 1) exactly when EL2 is enabled and `ctl_bcast` is 1. Requests issued at levels 2 and 3 are never inner-shareable.
- R5: The relaxed variant always sets `rsp_excl_xs`. For the plain variant, `rsp_excl_xs` is set only at level 1, and only when `feat_xattr`, `feat_hypext`, `ctl_xctl_on` and `ctl_xctl_fnx` are all 1. At levels 2 and 3, `ctl_xctl_fnx` has no effect.
- R6: At levels 2 and 3 with `host_mode` = 1, the request targets the EL2&0 regime (`rsp_host_regime` = 1) without a VMID. In every other invalidation request, including all of level 1, the request targets EL1&0 with the VMID (`rsp_use_vmid` = 1).
- R7: At level 3 with `feat_realm` = 1, the outcome is a no-op when the target security state is invalid. The target state is given by `sec_ok_el2` when `host_mode` = 1, and by `sec_ok_el1` otherwise. No other level ever yields a no-op.
- R8: On an invalidation request, `rsp_level` is 2'b00 (any level) and `rsp_operand` equals the accepted operand. On every other response, the attributes and the operand are zero.
- R9: For each accepted request, `rsp_valid` is high for exactly one cycle, in the cycle after acceptance, with exactly one of the four outcome bits set. In cycles that follow no request, every output is zero.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_el | input | 2 | Executing exception level, 0 to 3 |
| req_relaxed | input | 1 | 1 = relaxed variant, 0 = plain variant |
| req_operand | input | OPND_W | Instruction operand |
| feat_xattr | input | 1 | Extra-strict attribute feature present |
| feat_hypext | input | 1 | Hypervisor extended-control feature present |
| feat_finetrap | input | 1 | Fine-grained trap feature present |
| feat_el3 | input | 1 | EL3 implemented |
| feat_realm | input | 1 | Realm management feature present |
| el2_on | input | 1 | EL2 enabled in the current security state |
| ctl_tlb_trap | input | 1 | Hypervisor trap-TLB-maintenance control |
| ctl_bcast | input | 1 | Hypervisor force-broadcast control |
| ctl_fgt_en | input | 1 | Monitor enable for fine-grained traps |
| ctl_fgt_inst | input | 1 | Fine-grained trap bit for this instruction |
| ctl_xctl_on | input | 1 | Hypervisor extended-control register enabled |
| ctl_xctl_fnx | input | 1 | Extended control: treat plain variant as relaxed |
| ctl_xctl_fgtx | input | 1 | Extended control: exempt relaxed variant from fine-grained trap |
| host_mode | input | 1 | EL2 host regime active for EL0 |
| sec_ok_el1 | input | 1 | Security state at EL1 is valid |
| sec_ok_el2 | input | 1 | Security state at EL2 is valid |
| rsp_valid | output | 1 | Response pulse |
| rsp_undef | output | 1 | Outcome: undefined instruction |
| rsp_trap | output | 1 | Outcome: trap to EL2 |
| rsp_nop | output | 1 | Outcome: silent no-op |
| rsp_issue | output | 1 | Outcome: invalidation request |
| rsp_class | output | EC_W | Trap syndrome class |
| rsp_host_regime | output | 1 | 1 = EL2&0 regime, 0 = EL1&0 regime |
| rsp_inner | output | 1 | 1 = inner-shareable, 0 = non-shareable |
| rsp_use_vmid | output | 1 | Current VMID qualifies the request |
| rsp_excl_xs | output | 1 | Accesses with the extra-strict attribute are excluded |
| rsp_level | output | 2 | Level hint, 2'b00 = any level |
| rsp_operand | output | OPND_W | Operand forwarded unchanged |

## Verification
The bench builds the block with its default parameters: a 64-bit operand, a 6-bit syndrome class and a trap class of 0x18. The feature flags are ports rather than parameters, so this single build reaches every mix of present and absent features. That includes the combinations where the relaxed variant becomes undefined, and where the fine-grained trap is lost for lack of the hypervisor extension. Directed cases cover each priority edge, and a long random run then walks through the full product of level, variant and control bits. The run includes reset pulses that arrive while a request is being accepted.

// File: rtl/tlbi_gate_pkg.sv
package tlbi_gate_pkg;

  typedef enum logic [1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2,
    LVL3 = 2'd3
  } exc_lvl_e;

  localparam logic [1:0] HINT_ANY = 2'b00;

  typedef struct packed {
    logic       host_regime;
    logic       inner;
    logic       use_vmid;
    logic       excl_xs;
    logic [1:0] level;
  } inv_attr_t;

  // Fine-grained trap arming for this instruction; the relaxed variant
  // needs the extension present and not exempted by its control bit.
  function automatic logic fine_trap_armed(
    input logic relaxed,
    input logic has_ft,
    input logic has_el3,
    input logic ft_en,
    input logic inst_bit,
    input logic has_hext,
    input logic xctl_on,
    input logic xctl_ftx
  );
    logic base;
    base = has_ft && (!has_el3 || ft_en) && inst_bit;
    if (relaxed) return base && has_hext && (!xctl_on || !xctl_ftx);
    return base;
  endfunction

  // Whether accesses with the extra-strict attribute are left out.
  function automatic logic xattr_skip(
    input logic relaxed,
    input logic at_el1,
    input logic has_x,
    input logic has_hext,
    input logic xctl_on,
    input logic xctl_fnx
  );
    return relaxed || (at_el1 && has_x && has_hext && xctl_on && xctl_fnx);
  endfunction

endpackage

// File: rtl/tlbi_perm_tree.sv
module tlbi_perm_tree
  import tlbi_gate_pkg::*;
(
  input  exc_lvl_e lvl,
  input  logic     relaxed,
  input  logic     has_xattr,
  input  logic     has_hext,
  input  logic     has_ft,
  input  logic     has_el3,
  input  logic     has_realm,
  input  logic     el2_on,
  input  logic     tlb_trap,
  input  logic     ft_en,
  input  logic     ft_inst,
  input  logic     xctl_on,
  input  logic     xctl_ftx,
  input  logic     host,
  input  logic     ok_el1,
  input  logic     ok_el2,
  output logic     o_undef,
  output logic     o_trap,
  output logic     o_nop,
  output logic     o_issue
);

  logic variant_missing;
  logic coarse_hit;
  logic fine_hit;
  logic target_ok;

  assign variant_missing = relaxed && !has_xattr;
  assign coarse_hit      = el2_on && tlb_trap;
  assign fine_hit        = el2_on && fine_trap_armed(relaxed, has_ft, has_el3, ft_en,
                                                      ft_inst, has_hext, xctl_on, xctl_ftx);
  assign target_ok       = host ? ok_el2 : ok_el1;

  always_comb begin
    o_undef = 1'b0;
    o_trap  = 1'b0;
    o_nop   = 1'b0;
    o_issue = 1'b0;
    if (variant_missing) begin
      o_undef = 1'b1;
    end else begin
      unique case (lvl)
        LVL0: o_undef = 1'b1;
        LVL1: begin
          if (coarse_hit || fine_hit) o_trap  = 1'b1;
          else                        o_issue = 1'b1;
        end
        LVL2: o_issue = 1'b1;
        LVL3: begin
          if (has_realm && !target_ok) o_nop   = 1'b1;
          else                         o_issue = 1'b1;
        end
        default: o_undef = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/tlbi_attr_build.sv
module tlbi_attr_build
  import tlbi_gate_pkg::*;
(
  input  exc_lvl_e  lvl,
  input  logic      relaxed,
  input  logic      has_xattr,
  input  logic      has_hext,
  input  logic      el2_on,
  input  logic      bcast,
  input  logic      xctl_on,
  input  logic      xctl_fnx,
  input  logic      host,
  output inv_attr_t attr
);

  logic at_el1;
  logic host_sel;

  assign at_el1   = (lvl == LVL1);
  assign host_sel = !at_el1 && host;

  always_comb begin
    attr.host_regime = host_sel;
    attr.use_vmid    = !host_sel;
    attr.inner       = at_el1 && el2_on && bcast;
    attr.excl_xs     = xattr_skip(relaxed, at_el1, has_xattr, has_hext, xctl_on, xctl_fnx);
    attr.level       = HINT_ANY;
  end

endmodule

// File: rtl/tlbi_out_stage.sv
module tlbi_out_stage
  import tlbi_gate_pkg::*;
#(
  parameter int OPND_W = 64,
  parameter int EC_W   = 6,
  parameter logic [EC_W-1:0] EC_TRAP = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              d_undef,
  input  logic              d_trap,
  input  logic              d_nop,
  input  logic              d_issue,
  input  inv_attr_t         d_attr,
  input  logic [OPND_W-1:0] d_operand,
  output logic              q_valid,
  output logic [3:0]        q_outcome,
  output logic [EC_W-1:0]   q_class,
  output inv_attr_t         q_attr,
  output logic [OPND_W-1:0] q_operand
);

  localparam int OUTC_W = 4;

  logic [OUTC_W-1:0] next_outcome;
  logic              take_issue;
  logic              take_trap;

  assign next_outcome = in_valid ? {d_issue, d_nop, d_trap, d_undef} : '0;
  assign take_issue   = in_valid && d_issue;
  assign take_trap    = in_valid && d_trap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_outcome <= '0;
      q_class   <= '0;
      q_attr    <= '0;
      q_operand <= '0;
    end else begin
      q_valid   <= in_valid;
      q_outcome <= next_outcome;
      q_class   <= take_trap ? EC_TRAP : '0;
      q_attr    <= take_issue ? d_attr : '0;
      q_operand <= take_issue ? d_operand : '0;
    end
  end

endmodule

// File: rtl/tlbi_range_gate.sv
module tlbi_range_gate
  import tlbi_gate_pkg::*;
#(
  parameter int OPND_W = 64,
  parameter int EC_W   = 6,
  parameter logic [EC_W-1:0] EC_TRAP = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_el,
  input  logic              req_relaxed,
  input  logic [OPND_W-1:0] req_operand,
  input  logic              feat_xattr,
  input  logic              feat_hypext,
  input  logic              feat_finetrap,
  input  logic              feat_el3,
  input  logic              feat_realm,
  input  logic              el2_on,
  input  logic              ctl_tlb_trap,
  input  logic              ctl_bcast,
  input  logic              ctl_fgt_en,
  input  logic              ctl_fgt_inst,
  input  logic              ctl_xctl_on,
  input  logic              ctl_xctl_fnx,
  input  logic              ctl_xctl_fgtx,
  input  logic              host_mode,
  input  logic              sec_ok_el1,
  input  logic              sec_ok_el2,
  output logic              rsp_valid,
  output logic              rsp_undef,
  output logic              rsp_trap,
  output logic              rsp_nop,
  output logic              rsp_issue,
  output logic [EC_W-1:0]   rsp_class,
  output logic              rsp_host_regime,
  output logic              rsp_inner,
  output logic              rsp_use_vmid,
  output logic              rsp_excl_xs,
  output logic [1:0]        rsp_level,
  output logic [OPND_W-1:0] rsp_operand
);

  exc_lvl_e  lvl;
  logic      dec_undef, dec_trap, dec_nop, dec_issue;
  inv_attr_t dec_attr;
  logic [3:0] q_outcome;
  inv_attr_t  q_attr;

  assign lvl = exc_lvl_e'(req_el);

  tlbi_perm_tree u_perm (
    .lvl       (lvl),
    .relaxed   (req_relaxed),
    .has_xattr (feat_xattr),
    .has_hext  (feat_hypext),
    .has_ft    (feat_finetrap),
    .has_el3   (feat_el3),
    .has_realm (feat_realm),
    .el2_on    (el2_on),
    .tlb_trap  (ctl_tlb_trap),
    .ft_en     (ctl_fgt_en),
    .ft_inst   (ctl_fgt_inst),
    .xctl_on   (ctl_xctl_on),
    .xctl_ftx  (ctl_xctl_fgtx),
    .host      (host_mode),
    .ok_el1    (sec_ok_el1),
    .ok_el2    (sec_ok_el2),
    .o_undef   (dec_undef),
    .o_trap    (dec_trap),
    .o_nop     (dec_nop),
    .o_issue   (dec_issue)
  );

  tlbi_attr_build u_attr (
    .lvl       (lvl),
    .relaxed   (req_relaxed),
    .has_xattr (feat_xattr),
    .has_hext  (feat_hypext),
    .el2_on    (el2_on),
    .bcast     (ctl_bcast),
    .xctl_on   (ctl_xctl_on),
    .xctl_fnx  (ctl_xctl_fnx),
    .host      (host_mode),
    .attr      (dec_attr)
  );

  tlbi_out_stage #(
    .OPND_W  (OPND_W),
    .EC_W    (EC_W),
    .EC_TRAP (EC_TRAP)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .d_undef   (dec_undef),
    .d_trap    (dec_trap),
    .d_nop     (dec_nop),
    .d_issue   (dec_issue),
    .d_attr    (dec_attr),
    .d_operand (req_operand),
    .q_valid   (rsp_valid),
    .q_outcome (q_outcome),
    .q_class   (rsp_class),
    .q_attr    (q_attr),
    .q_operand (rsp_operand)
  );

  assign {rsp_issue, rsp_nop, rsp_trap, rsp_undef} = q_outcome;
  assign rsp_host_regime = q_attr.host_regime;
  assign rsp_inner       = q_attr.inner;
  assign rsp_use_vmid    = q_attr.use_vmid;
  assign rsp_excl_xs     = q_attr.excl_xs;
  assign rsp_level       = q_attr.level;

  // Checks on the registered response against the accepted request
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_undef, rsp_trap, rsp_nop, rsp_issue}) == 1); // R9
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_undef, rsp_trap, rsp_nop, rsp_issue} == 4'b0 && rsp_operand == '0)); // R9
  AST_PULSE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R9
  AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && $past(req_el) == 2'd0) |-> rsp_undef); // R1
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_class == EC_TRAP); // R2
  AST_CLASS_ONLY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_trap |-> rsp_class == '0); // R2
  AST_RELAXED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_issue && $past(req_relaxed)) |-> rsp_excl_xs); // R5
  AST_REGIME_VMID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_issue |-> (rsp_host_regime != rsp_use_vmid)); // R6
  AST_HOST_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_issue && rsp_host_regime) |-> !rsp_inner); // R6
  AST_NOP_ONLY_L3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nop |-> $past(req_el) == 2'd3); // R7
  AST_OPND_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_issue |-> rsp_operand == $past(req_operand)); // R8

endmodule

// File: tb/tlbi_range_gate_tb.sv
module tlbi_range_gate_tb_top;

  localparam int OPND_W = 64;
  localparam int EC_W   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_el = '0;
  logic req_relaxed = 1'b0;
  logic [OPND_W-1:0] req_operand = '0;
  logic feat_xattr = 0, feat_hypext = 0, feat_finetrap = 0, feat_el3 = 0, feat_realm = 0;
  logic el2_on = 0, ctl_tlb_trap = 0, ctl_bcast = 0, ctl_fgt_en = 0, ctl_fgt_inst = 0;
  logic ctl_xctl_on = 0, ctl_xctl_fnx = 0, ctl_xctl_fgtx = 0;
  logic host_mode = 0, sec_ok_el1 = 0, sec_ok_el2 = 0;

  logic rsp_valid, rsp_undef, rsp_trap, rsp_nop, rsp_issue;
  logic [EC_W-1:0] rsp_class;
  logic rsp_host_regime, rsp_inner, rsp_use_vmid, rsp_excl_xs;
  logic [1:0] rsp_level;
  logic [OPND_W-1:0] rsp_operand;

  // expected response for the request driven at the previous falling edge
  logic e_valid, e_undef, e_trap, e_nop, e_issue, e_host, e_inner, e_vmid, e_excl;
  int unsigned e_class;
  logic [1:0] e_level;
  logic [OPND_W-1:0] e_operand;

  int checks = 0;
  int fails  = 0;
  bit in_reset_phase = 1'b1;

  always #2 clk = ~clk;

  tlbi_range_gate #(.OPND_W(OPND_W), .EC_W(EC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_el(req_el),
    .req_relaxed(req_relaxed), .req_operand(req_operand),
    .feat_xattr(feat_xattr), .feat_hypext(feat_hypext), .feat_finetrap(feat_finetrap),
    .feat_el3(feat_el3), .feat_realm(feat_realm), .el2_on(el2_on),
    .ctl_tlb_trap(ctl_tlb_trap), .ctl_bcast(ctl_bcast), .ctl_fgt_en(ctl_fgt_en),
    .ctl_fgt_inst(ctl_fgt_inst), .ctl_xctl_on(ctl_xctl_on), .ctl_xctl_fnx(ctl_xctl_fnx),
    .ctl_xctl_fgtx(ctl_xctl_fgtx), .host_mode(host_mode), .sec_ok_el1(sec_ok_el1),
    .sec_ok_el2(sec_ok_el2),
    .rsp_valid(rsp_valid), .rsp_undef(rsp_undef), .rsp_trap(rsp_trap), .rsp_nop(rsp_nop),
    .rsp_issue(rsp_issue), .rsp_class(rsp_class), .rsp_host_regime(rsp_host_regime),
    .rsp_inner(rsp_inner), .rsp_use_vmid(rsp_use_vmid), .rsp_excl_xs(rsp_excl_xs),
    .rsp_level(rsp_level), .rsp_operand(rsp_operand)
  );

  task automatic clear_expect();
    e_valid = 0; e_undef = 0; e_trap = 0; e_nop = 0; e_issue = 0;
    e_host = 0; e_inner = 0; e_vmid = 0; e_excl = 0; e_class = 0;
    e_level = 2'b00; e_operand = '0;
  endtask

  // Behavioural reference written from the requirements
  task automatic predict();
    bit armed;
    bit ok;
    clear_expect();
    if (!rst_n || !req_valid) return;                    // R10 R9
    e_valid = 1;
    if (req_relaxed && !feat_xattr) begin e_undef = 1; return; end   // R1
    if (req_el == 0) begin e_undef = 1; return; end                  // R1
    if (req_el == 1) begin
      armed = feat_finetrap && (!feat_el3 || ctl_fgt_en) && ctl_fgt_inst;          // R3
      if (req_relaxed) armed = armed && feat_hypext && !(ctl_xctl_on && ctl_xctl_fgtx);
      if (el2_on && (ctl_tlb_trap || armed)) begin e_trap = 1; e_class = 24; return; end  // R2
      e_issue = 1; e_host = 0; e_vmid = 1;
      e_inner = el2_on && ctl_bcast;                                                // R4
      e_excl  = req_relaxed || (feat_xattr && feat_hypext && ctl_xctl_on && ctl_xctl_fnx); // R5
    end else begin
      ok = host_mode ? sec_ok_el2 : sec_ok_el1;
      if (req_el == 3 && feat_realm && !ok) begin e_nop = 1; return; end           // R7
      e_issue = 1; e_host = host_mode; e_vmid = !host_mode; e_excl = req_relaxed;  // R6 R5
    end
    e_operand = req_operand;                                                        // R8
  endtask

  task automatic field(input string tag, input string name, input longint unsigned act,
                       input longint unsigned exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s actual %0h expected %0h at %0t",
               in_reset_phase ? "R10" : tag, name, act, exp, $time);
      bad = 1;
    end
  endtask

  task automatic edge_and_check();
    bit bad;
    @(negedge clk);
    bad = 0;
    checks++;
    field("R9", "valid", rsp_valid, e_valid, bad);
    field("R1", "undef", rsp_undef, e_undef, bad);
    field("R2 R3", "trap", rsp_trap, e_trap, bad);
    field("R7", "nop", rsp_nop, e_nop, bad);
    field("R9", "issue", rsp_issue, e_issue, bad);
    field("R2", "class", rsp_class, e_class, bad);
    field("R6", "host_regime", rsp_host_regime, e_host, bad);
    field("R4", "inner", rsp_inner, e_inner, bad);
    field("R6", "use_vmid", rsp_use_vmid, e_vmid, bad);
    field("R5", "excl_xs", rsp_excl_xs, e_excl, bad);
    field("R8", "level", rsp_level, e_level, bad);
    field("R8", "operand", rsp_operand[63:0], e_operand[63:0], bad);
    if (bad) fails++;
  endtask

  task automatic set_base(input logic [1:0] lvl, input logic rel);
    req_valid = 1; req_el = lvl; req_relaxed = rel;
    req_operand = {$urandom, $urandom};
    feat_xattr = 1; feat_hypext = 1; feat_finetrap = 1; feat_el3 = 1; feat_realm = 1;
    el2_on = 1; ctl_tlb_trap = 0; ctl_bcast = 0; ctl_fgt_en = 1; ctl_fgt_inst = 0;
    ctl_xctl_on = 0; ctl_xctl_fnx = 0; ctl_xctl_fgtx = 0;
    host_mode = 0; sec_ok_el1 = 1; sec_ok_el2 = 1;
  endtask

  task automatic step();
    predict();
    edge_and_check();
  endtask

  task automatic randomize_inputs();
    req_valid = ($urandom % 4) != 0;
    req_el = 2'($urandom); req_relaxed = 1'($urandom);
    req_operand = {$urandom, $urandom};
    feat_xattr = 1'($urandom); feat_hypext = 1'($urandom); feat_finetrap = 1'($urandom);
    feat_el3 = 1'($urandom); feat_realm = 1'($urandom); el2_on = 1'($urandom);
    ctl_tlb_trap = 1'($urandom); ctl_bcast = 1'($urandom); ctl_fgt_en = 1'($urandom);
    ctl_fgt_inst = 1'($urandom); ctl_xctl_on = 1'($urandom); ctl_xctl_fnx = 1'($urandom);
    ctl_xctl_fgtx = 1'($urandom); host_mode = 1'($urandom);
    sec_ok_el1 = 1'($urandom); sec_ok_el2 = 1'($urandom);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    clear_expect();
    // R10: reset state, with a request already presented
    req_valid = 1; req_operand = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < 3; i++) step();
    rst_n = 1; in_reset_phase = 0;
    req_valid = 0; step();                                  // R9 idle after reset

    set_base(2'd0, 0); step();                              // R1 level 0 plain
    set_base(2'd0, 1); step();                              // R1 level 0 relaxed
    set_base(2'd2, 1); feat_xattr = 0; step();              // R1 relaxed without feature
    set_base(2'd1, 1); feat_xattr = 0; ctl_tlb_trap = 1; step(); // R1 ahead of trap
    set_base(2'd1, 0); ctl_tlb_trap = 1; step();            // R2 coarse trap
    set_base(2'd1, 0); ctl_tlb_trap = 1; el2_on = 0; step(); // R2 needs EL2
    set_base(2'd1, 0); ctl_fgt_inst = 1; step();            // R3 fine trap plain
    set_base(2'd1, 0); ctl_fgt_inst = 1; feat_el3 = 0; ctl_fgt_en = 0; step(); // R3 no EL3
    set_base(2'd1, 0); ctl_fgt_inst = 1; ctl_fgt_en = 0; step(); // R3 disabled by monitor
    set_base(2'd1, 1); ctl_fgt_inst = 1; ctl_xctl_on = 1; ctl_xctl_fgtx = 1; step(); // R3 exempt
    set_base(2'd1, 1); ctl_fgt_inst = 1; feat_hypext = 0; step(); // R3 no extension
    set_base(2'd1, 1); ctl_fgt_inst = 1; step();            // R3 relaxed traps
    set_base(2'd1, 0); ctl_bcast = 1; step();               // R4 inner
    set_base(2'd1, 0); ctl_bcast = 1; el2_on = 0; step();   // R4 non-shareable
    set_base(2'd2, 0); ctl_bcast = 1; step();               // R4 EL2 never inner
    set_base(2'd1, 0); ctl_xctl_on = 1; ctl_xctl_fnx = 1; step(); // R5 plain excludes
    set_base(2'd2, 0); ctl_xctl_on = 1; ctl_xctl_fnx = 1; step(); // R5 no effect at EL2
    set_base(2'd3, 1); step();                              // R5 relaxed always
    set_base(2'd2, 0); host_mode = 1; step();               // R6 host regime
    set_base(2'd1, 0); host_mode = 1; step();               // R6 EL1 ignores host
    set_base(2'd3, 0); sec_ok_el1 = 0; step();              // R7 nop
    set_base(2'd3, 0); host_mode = 1; sec_ok_el1 = 0; step(); // R7 uses EL2 state
    set_base(2'd3, 0); host_mode = 1; sec_ok_el2 = 0; step(); // R7 nop host
    set_base(2'd2, 0); sec_ok_el1 = 0; step();              // R7 never at EL2
    set_base(2'd3, 0); sec_ok_el1 = 0; feat_realm = 0; step(); // R7 needs realm
    set_base(2'd2, 0); req_operand = '1; step();            // R8 all ones
    set_base(2'd2, 0); req_operand = 64'h8000_0000_0000_0001; step(); // R8 edges
    req_valid = 0; step();                                  // R9 pulse ends

    for (int n = 0; n < 4000; n++) begin
      randomize_inputs();
      if (n % 997 == 500) begin
        rst_n = 0; step(); rst_n = 1;                       // R10 mid-run reset
      end else begin
        step();
      end
    end
    req_valid = 0; step();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule